// File: doc/BRIEF.md
# Key-Locked Pad Configuration Bank

This block holds the pad configuration of one 8-pin I/O port behind a two-level guard. The first level is a key lock: software must write a 32-bit magic key to the lock register before the per-pin commit mask can be changed. The second level is the commit mask itself. For every pin whose commit bit is clear, the pin's alternate-select, pull-up, pull-down and digital-enable bits keep their values on any write. A pin cannot have both its pull-up and its pull-down selected. Setting either one clears the other on the same pin.

A direction register sits in the same bank with no protection. Its outputs are plain register bits. Access uses a word-addressed port with separate write and read strobes. A read returns its data one cycle after the strobe, qualified by a valid flag. The per-pin configuration vectors leave the block as plain outputs toward the pad logic.

Top module: `pad_cfg_bank`

## Requirements
- R1: After reset the bank is locked, the commit mask is all ones (set by a parameter), and the direction, alternate-select, pull-up, pull-down and digital-enable vectors are all zero.
- R2: Writing exactly 0x4C4F434B to the lock register unlocks the bank. The lock register then reads 0.
- R3: Writing any other 32-bit value to the lock register locks the bank, including a value that differs from the key in one bit. The lock register then reads 1.
- R4: A write to the commit register while the bank is locked leaves the commit mask unchanged.
- R5: A write to the commit register while the bank is unlocked loads the commit mask from the low 8 data bits.
- R6: On a write to alternate-select, pull-up, pull-down or digital-enable, a pin whose commit bit is 0 keeps its old value, and a pin whose commit bit is 1 takes the written bit.
- R7: Writing 1 to a committed pin's pull-up bit clears that pin's pull-down bit.
- R8: Writing 1 to a committed pin's pull-down bit clears that pin's pull-up bit.
- R9: The direction register (1 = output, 0 = input) takes every written bit, whatever the lock and commit state.
- R10: A read strobe returns data on the next cycle with the valid flag high. The word offsets are: 0 direction, 1 alternate-select, 2 pull-up, 3 pull-down, 4 digital enable, 5 lock (bit 0), 6 commit. Every other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 4 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read strobe |
| rvalid_o | output | 1 | Read data valid |
| dir_o | output | 8 | Per-pin direction |
| alt_o | output | 8 | Per-pin alternate-function select |
| pu_o | output | 8 | Per-pin pull-up enable |
| pd_o | output | 8 | Per-pin pull-down enable |
| den_o | output | 8 | Per-pin digital enable |

## Verification
The hardest case is a bank where the commit mask is only partly set. Protected and free pins must then be told apart within one write. The mask resets to all ones, so that state exists only after an unlock, a commit write and a relock. The stimulus first builds a known alternate-select pattern while every pin is free. It then unlocks, commits only the low nibble, relocks, and writes all ones to the gated registers. The read-back must show the old upper nibble next to the new lower nibble. A rejected commit write after the relock shows that the mask has stayed frozen.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'h4C4F_434B;

  localparam int unsigned OFS_DIR    = 0;
  localparam int unsigned OFS_ALT    = 1;
  localparam int unsigned OFS_PU     = 2;
  localparam int unsigned OFS_PD     = 3;
  localparam int unsigned OFS_DEN    = 4;
  localparam int unsigned OFS_LOCK   = 5;
  localparam int unsigned OFS_COMMIT = 6;

  typedef struct packed {
    logic dir;
    logic alt;
    logic pu;
    logic pd;
    logic den;
    logic lock;
    logic commit;
  } wr_sel_t;
endpackage

// File: rtl/pad_cfg_lock.sv
module pad_cfg_lock
  import pad_cfg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic        locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   locked_o <= 1'b1;
    else if (wr_i) locked_o <= (wdata_i != UNLOCK_KEY);
  end
endmodule

// File: rtl/pad_cfg_commit.sv
module pad_cfg_commit #(
  parameter int unsigned NPIN = 8,
  parameter logic [NPIN-1:0] RST_VAL = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            locked_i,
  input  logic [NPIN-1:0] wdata_i,
  output logic [NPIN-1:0] commit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                commit_o <= RST_VAL;
    else if (wr_i && !locked_i) commit_o <= wdata_i;
  end
endmodule

// File: rtl/pad_cfg_pin.sv
module pad_cfg_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic commit_i,
  input  logic wr_alt_i,
  input  logic wr_pu_i,
  input  logic wr_pd_i,
  input  logic wr_den_i,
  input  logic wbit_i,
  output logic alt_o,
  output logic pu_o,
  output logic pd_o,
  output logic den_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alt_o <= 1'b0;
      pu_o  <= 1'b0;
      pd_o  <= 1'b0;
      den_o <= 1'b0;
    end else if (commit_i) begin
      if (wr_alt_i) alt_o <= wbit_i;
      if (wr_den_i) den_o <= wbit_i;
      // pulls are exclusive: setting one drops the other
      if (wr_pu_i) begin
        pu_o <= wbit_i;
        if (wbit_i) pd_o <= 1'b0;
      end
      if (wr_pd_i) begin
        pd_o <= wbit_i;
        if (wbit_i) pu_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pad_cfg_bank.sv
module pad_cfg_bank
  import pad_cfg_pkg::*;
#(
  parameter int unsigned NPIN = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DW = 32,
  parameter logic [NPIN-1:0] COMMIT_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o,
  output logic [NPIN-1:0]   dir_o,
  output logic [NPIN-1:0]   alt_o,
  output logic [NPIN-1:0]   pu_o,
  output logic [NPIN-1:0]   pd_o,
  output logic [NPIN-1:0]   den_o
);
  localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_ALT    = ADDR_W'(OFS_ALT);
  localparam logic [ADDR_W-1:0] A_PU     = ADDR_W'(OFS_PU);
  localparam logic [ADDR_W-1:0] A_PD     = ADDR_W'(OFS_PD);
  localparam logic [ADDR_W-1:0] A_DEN    = ADDR_W'(OFS_DEN);
  localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(OFS_LOCK);
  localparam logic [ADDR_W-1:0] A_COMMIT = ADDR_W'(OFS_COMMIT);

  wr_sel_t         wsel;
  logic            locked_q;
  logic [NPIN-1:0] commit_q;
  logic [DW-1:0]   rd_mux;

  always_comb begin
    wsel        = '0;
    wsel.dir    = wr_en_i && (addr_i == A_DIR);
    wsel.alt    = wr_en_i && (addr_i == A_ALT);
    wsel.pu     = wr_en_i && (addr_i == A_PU);
    wsel.pd     = wr_en_i && (addr_i == A_PD);
    wsel.den    = wr_en_i && (addr_i == A_DEN);
    wsel.lock   = wr_en_i && (addr_i == A_LOCK);
    wsel.commit = wr_en_i && (addr_i == A_COMMIT);
  end

  pad_cfg_lock u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wsel.lock),
    .wdata_i  (wdata_i),
    .locked_o (locked_q)
  );

  pad_cfg_commit #(.NPIN(NPIN), .RST_VAL(COMMIT_RST)) u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wsel.commit),
    .locked_i (locked_q),
    .wdata_i  (wdata_i[NPIN-1:0]),
    .commit_o (commit_q)
  );

  // direction is free of lock and commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_o <= '0;
    else if (wsel.dir) dir_o <= wdata_i[NPIN-1:0];
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    pad_cfg_pin u_pin (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .commit_i (commit_q[p]),
      .wr_alt_i (wsel.alt),
      .wr_pu_i  (wsel.pu),
      .wr_pd_i  (wsel.pd),
      .wr_den_i (wsel.den),
      .wbit_i   (wdata_i[p]),
      .alt_o    (alt_o[p]),
      .pu_o     (pu_o[p]),
      .pd_o     (pd_o[p]),
      .den_o    (den_o[p])
    );
  end

  always_comb begin
    unique case (addr_i)
      A_DIR:    rd_mux = DW'(dir_o);
      A_ALT:    rd_mux = DW'(alt_o);
      A_PU:     rd_mux = DW'(pu_o);
      A_PD:     rd_mux = DW'(pd_o);
      A_DEN:    rd_mux = DW'(den_o);
      A_LOCK:   rd_mux = DW'(locked_q);
      A_COMMIT: rd_mux = DW'(commit_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/pad_cfg_bank_chk.sv
module pad_cfg_bank_chk
  import pad_cfg_pkg::*;
#(
  parameter int unsigned NPIN = 8,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              locked_q,
  input logic [NPIN-1:0]   commit_q,
  input logic [NPIN-1:0]   dir_o,
  input logic [NPIN-1:0]   alt_o,
  input logic [NPIN-1:0]   pu_o,
  input logic [NPIN-1:0]   pd_o,
  input logic [NPIN-1:0]   den_o
);
  // R2
  key_unlocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFS_LOCK) && wdata_i == UNLOCK_KEY) |=> !locked_q);

  // R3
  other_relocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFS_LOCK) && wdata_i != UNLOCK_KEY) |=> locked_q);

  // R4
  commit_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && !(wr_en_i && addr_i == ADDR_W'(OFS_LOCK))) |=> $stable(commit_q));

  // R6
  alt_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((alt_o ^ $past(alt_o)) & ~$past(commit_q)) == '0);

  // R6
  den_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((den_o ^ $past(den_o)) & ~$past(commit_q)) == '0);

  // R6
  pull_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((pu_o ^ $past(pu_o)) | (pd_o ^ $past(pd_o))) & ~$past(commit_q)) == '0);

  // R7 R8
  pull_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_o & pd_o) == '0);

  // R9
  dir_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFS_DIR)) |=> dir_o == $past(wdata_i[NPIN-1:0]));
endmodule

bind pad_cfg_bank pad_cfg_bank_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .locked_q (locked_q),
  .commit_q (commit_q),
  .dir_o    (dir_o),
  .alt_o    (alt_o),
  .pu_o     (pu_o),
  .pd_o     (pd_o),
  .den_o    (den_o)
);

// File: tb/test_pad_cfg_bank.sv
module test_pad_cfg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [7:0]  dir, alt, pu, pd, den;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  pad_cfg_bank i_pad_cfg_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .dir_o(dir), .alt_o(alt), .pu_o(pu), .pd_o(pd), .den_o(den)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops one expectation per valid read beat
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected read", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state at the pins
    check("R1 dir", 32'(dir), 0);
    check("R1 alt", 32'(alt), 0);
    check("R1 pu/pd", 32'({pu, pd}), 0);
    check("R1 den", 32'(den), 0);
    check("R1 rvalid", 32'(rvalid), 0);
    rst_n = 1'b1;
    rd(4'd5, 32'h1, "R1 lock after reset");
    rd(4'd6, 32'hFF, "R1 commit after reset");
    rd(4'd4, 32'h0, "R1 den after reset");

    wr(4'd6, 32'h0F);
    rd(4'd6, 32'hFF, "R4 commit write while locked");

    wr(4'd1, 32'hA5);
    rd(4'd1, 32'hA5, "R6 alt all committed");

    wr(4'd2, 32'h0F);
    wr(4'd3, 32'h03);
    rd(4'd3, 32'h03, "R8 pd set");
    rd(4'd2, 32'h0C, "R8 pu cleared by pd");
    wr(4'd2, 32'h01);
    rd(4'd2, 32'h01, "R7 pu set");
    rd(4'd3, 32'h02, "R7 pd cleared by pu");

    wr(4'd5, 32'h4C4F434B);
    rd(4'd5, 32'h0, "R2 unlocked by key");
    wr(4'd6, 32'h0F);
    rd(4'd6, 32'h0F, "R5 commit write while unlocked");
    wr(4'd5, 32'h4C4F434A);
    rd(4'd5, 32'h1, "R3 near-key relocks");
    wr(4'd5, 32'h4C4F434B);
    wr(4'd5, 32'h12345678);
    rd(4'd5, 32'h1, "R3 other value relocks");
    wr(4'd6, 32'h00);
    rd(4'd6, 32'h0F, "R4 relocked commit frozen");

    wr(4'd1, 32'hFF);
    rd(4'd1, 32'hAF, "R6 alt partial commit");
    wr(4'd4, 32'hFF);
    rd(4'd4, 32'h0F, "R6 den partial commit");
    @(negedge clk);
    check("R6 den pins", 32'(den), 32'h0F);
    wr(4'd3, 32'hF0);
    rd(4'd3, 32'h0, "R6 pd partial commit");
    rd(4'd2, 32'h01, "R6 pu untouched by pd zeros");

    wr(4'd0, 32'h3C);
    rd(4'd0, 32'h3C, "R9 dir ungated");
    @(negedge clk);
    check("R9 dir pins", 32'(dir), 32'h3C);

    rd(4'd7, 32'h0, "R10 unmapped offset");
    rd(4'd15, 32'h0, "R10 top offset");

    repeat (3) @(negedge clk);
    check("R10 pending reads", 32'(exp_q.size()), 0);
    done = 1'b1;
    finish_run();
  end
endmodule